// File: doc/BRIEF.md
# Two-Bank Shadowed Word Store with Safe Commit

This block puts a small word-addressed shadow store in front of a non-volatile memory that is divided into two banks of equal size. Host writes go only into the shadow and mark the entry as changed. Host reads return the shadow copy of a changed word. For any other word the block fetches it from the bank that currently holds valid contents.

A commit request moves the pending changes into non-volatile memory without ever leaving the store in a state where no bank is valid. The block first finds the valid bank by its signature word. It erases the other bank and copies every shadow-sized word into it. Changed words come from the shadow and unchanged words come from the same index of the old bank. During the copy the new bank's signature is kept in an "unfinished" state. After the copy, the block marks the new bank valid and retires the old bank. Both of these steps only clear bits, so neither needs an erase.

The memory side is a single request/acknowledge port with three operations: read a 16-bit word, program one byte, and erase one bank.

Top module: `nvm_shadow_commit`

## Requirements
- R1: A host read of a word whose changed flag is set returns the shadow value with `hr_valid` high in the cycle after the request is taken, and causes no memory operation.
- R2: A host read of an unchanged word issues one read (`nv_op` = 0) at byte address 2·(word + base), where base is 0 for bank 0 and BANK_WORDS for bank 1. It returns `nv_rword`. The bank used is the one found valid by the latest commit, or bank 0 after reset.
- R3: An accepted host write pulses `hw_acc`. It then stores `hw_len` beats at words `hw_off`, `hw_off`+1, and so on, and sets each word's changed flag. No memory operation occurs.
- R4: A host write with `hw_off` ≥ WORDS, with `hw_len` = 0, or with `hw_off`+`hw_len` > WORDS pulses `hw_rej` and leaves every shadow entry unchanged.
- R5: A commit first reads the signature word (index SIG_WORD) of bank 0 and then of bank 1. A bank is valid when bits 15:14 of its signature are 10b, and bank 0 is checked first. If neither bank is valid, `commit_fail` pulses and no further memory operation follows.
- R6: The bank opposite the valid one is erased (`nv_op` = 2, address = its first byte) before any program operation.
- R7: Words 0 to WORDS-1 are copied in ascending order. The source is the shadow value if the word is changed; otherwise the block reads the same index of the old bank. Each word is programmed (`nv_op` = 1) as its low byte at 2·(i + base) and then its high byte at the next address.
- R8: While the signature word is copied, its bits 15:14 are forced to 11b.
- R9: After the copy, the new signature word is read back and its high byte is reprogrammed with bit 6 cleared (word bit 14), so bits 15:14 become 10b.
- R10: The old bank's signature high byte is then programmed to 0x00. After that, `commit_ok` pulses, every shadow entry becomes unchanged with value 0xFFFF, and later reads use the new bank.
- R11: A failed program or erase (`nv_fail` with `nv_ack`) ends the commit with a `commit_fail` pulse. No further operation is issued, the new bank is not validated, and the shadow is kept.
- R12: `busy` is high from the cycle after a commit is taken until its outcome pulse, and it is low in the cycle of that pulse. Host requests presented while busy are not taken. A memory request holds `nv_op` and `nv_addr` stable until it is acknowledged.
- R13: After reset, every shadow entry is unchanged with value 0xFFFF, and `busy`, `hr_valid`, `hw_acc`, `hw_rej`, `commit_ok`, `commit_fail` and `nv_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hr_req | input | 1 | Host read request, taken when not busy |
| hr_idx | input | IDX_W | Word index to read |
| hr_valid | output | 1 | Read data valid pulse |
| hr_data | output | 16 | Read data |
| hw_req | input | 1 | Host write request, taken when not busy |
| hw_off | input | IDX_W+1 | First word of the write |
| hw_len | input | IDX_W+1 | Number of words |
| hw_beat | input | 1 | One data word present on `hw_data` |
| hw_data | input | 16 | Write data beat |
| hw_acc | output | 1 | Write accepted pulse |
| hw_rej | output | 1 | Write rejected pulse |
| commit_req | input | 1 | Start a commit, taken when not busy |
| busy | output | 1 | Block is in a multi-cycle operation |
| commit_ok | output | 1 | Commit completed pulse |
| commit_fail | output | 1 | Commit failed pulse |
| nv_req | output | 1 | Memory operation request |
| nv_op | output | 2 | 0 read word, 1 program byte, 2 erase bank |
| nv_addr | output | FA_W | Byte address |
| nv_wbyte | output | 8 | Byte to program |
| nv_ack | input | 1 | Operation finished |
| nv_fail | input | 1 | Operation failed, valid with `nv_ack` |
| nv_rword | input | 16 | Read word, low byte at the even address |

## Verification
The hardest case to reach is a failure partway through a copy. It needs a valid bank that was itself produced by an earlier commit, pending shadow changes, and a program failure on one chosen byte after the erase. The bench's memory model gets there by counting program operations across the whole run and failing the fifth one of the second commit. The bench then confirms that the earlier bank's signature is untouched, that the half-written bank was never validated, and that the pending shadow word still answers reads without any memory access. A later run corrupts the surviving signature so that the no-valid-bank path can be driven from the same state.

// File: rtl/nvm_shadow_pkg.sv
package nvm_shadow_pkg;

   localparam int NV_WORD_W = 16;
   localparam int NV_BYTE_W = 8;

   // memory operation codes seen on the port
   localparam logic [1:0] NV_OP_READ  = 2'd0;
   localparam logic [1:0] NV_OP_PROG  = 2'd1;
   localparam logic [1:0] NV_OP_ERASE = 2'd2;

   // signature field codes, bits 15:14 of the signature word
   localparam logic [1:0] SIG_CODE_VALID = 2'b10;
   localparam logic [1:0] SIG_CODE_BUSY  = 2'b11;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HRD,
      S_HWR,
      S_DET0,
      S_DET1,
      S_ERASE,
      S_PICK,
      S_CPRD,
      S_CPLO,
      S_CPHI,
      S_VRD,
      S_VHI,
      S_INV
   } seq_state_e;

endpackage

// File: rtl/nvm_shadow_store.sv
module nvm_shadow_store
   import nvm_shadow_pkg::*;
#(
   parameter int WORDS = 32,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [IDX_W-1:0]     waddr,
   input  logic [NV_WORD_W-1:0] wdata,
   input  logic                 clr,
   input  logic [IDX_W-1:0]     raddr,
   output logic                 rmod,
   output logic [NV_WORD_W-1:0] rval
);

   logic                 mod_q [WORDS];
   logic [NV_WORD_W-1:0] val_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < WORDS; e++) begin
            mod_q[e] <= 1'b0;
            val_q[e] <= '1;
         end
      end else if (clr) begin
         for (int e = 0; e < WORDS; e++) begin
            mod_q[e] <= 1'b0;
            val_q[e] <= '1;
         end
      end else if (we) begin
         mod_q[waddr] <= 1'b1;
         val_q[waddr] <= wdata;
      end
   end

   assign rmod = mod_q[raddr];
   assign rval = val_q[raddr];

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_chk
         // R3: a written entry holds the beat and its changed flag afterwards
         a_r3_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !clr && waddr == IDX_W'(g)) |=> (mod_q[g] && val_q[g] == $past(wdata)));
         // R10: a clear leaves the entry unchanged at all ones
         a_r10_entry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (!mod_q[g] && val_q[g] == '1));
      end
   endgenerate

endmodule

// File: rtl/nvm_bank_pick.sv
module nvm_bank_pick
   import nvm_shadow_pkg::*;
#(
   parameter logic [1:0] GOOD_CODE = SIG_CODE_VALID
) (
   input  logic [1:0] fld0,
   input  logic [1:0] fld1,
   output logic       found,
   output logic       pick
);

   logic ok0, ok1;

   assign ok0   = (fld0 == GOOD_CODE);
   assign ok1   = (fld1 == GOOD_CODE);
   assign found = ok0 || ok1;
   // bank 0 wins when both look valid
   assign pick  = !ok0;

endmodule

// File: rtl/nvm_shadow_commit.sv
module nvm_shadow_commit
   import nvm_shadow_pkg::*;
#(
   parameter int WORDS      = 32,
   parameter int BANK_WORDS = 64,
   parameter int SIG_WORD   = 19,
   localparam int IDX_W     = $clog2(WORDS),
   localparam int WADDR_W   = $clog2(2 * BANK_WORDS),
   localparam int FA_W      = WADDR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hr_req,
   input  logic [IDX_W-1:0] hr_idx,
   output logic             hr_valid,
   output logic [15:0]      hr_data,
   input  logic             hw_req,
   input  logic [IDX_W:0]   hw_off,
   input  logic [IDX_W:0]   hw_len,
   input  logic             hw_beat,
   input  logic [15:0]      hw_data,
   output logic             hw_acc,
   output logic             hw_rej,
   input  logic             commit_req,
   output logic             busy,
   output logic             commit_ok,
   output logic             commit_fail,
   output logic             nv_req,
   output logic [1:0]       nv_op,
   output logic [FA_W-1:0]  nv_addr,
   output logic [7:0]       nv_wbyte,
   input  logic             nv_ack,
   input  logic             nv_fail,
   input  logic [15:0]      nv_rword
);

   localparam logic [IDX_W-1:0]     SIG_IDX  = IDX_W'(SIG_WORD);
   localparam logic [IDX_W-1:0]     LAST_IDX = IDX_W'(WORDS - 1);
   localparam logic [NV_WORD_W-1:0] SIG_HOLD = {SIG_CODE_BUSY, {(NV_WORD_W-2){1'b0}}};

   initial begin
      assert (WORDS > 1) else $error("WORDS must exceed one");
      assert (WORDS <= BANK_WORDS) else $error("shadow larger than a bank");
      assert (SIG_WORD < WORDS) else $error("signature word outside shadow");
   end

   seq_state_e             st;
   logic                   act_bank, old_bank;
   logic [IDX_W-1:0]       cidx, ridx, wbase;
   logic [IDX_W:0]         wcnt, wlen;
   logic [NV_WORD_W-1:0]   cword;
   logic [1:0]             sig0_fld;

   logic                   s_we, s_clr, s_mod;
   logic [IDX_W-1:0]       s_waddr, s_raddr;
   logic [NV_WORD_W-1:0]   s_val;
   logic                   sel_found, sel_bank;
   logic [IDX_W+1:0]       wr_end;
   logic                   wr_bad;
   logic                   new_bank;
   logic [NV_WORD_W-1:0]   sig_or;

   function automatic logic [FA_W-1:0] byte_at(input logic bank,
                                                input logic [IDX_W-1:0] w,
                                                input logic hi);
      logic [WADDR_W-1:0] wa;
      wa = WADDR_W'(w) + (bank ? WADDR_W'(BANK_WORDS) : '0);
      return {wa, hi};
   endfunction

   assign new_bank = ~old_bank;
   assign wr_end   = {1'b0, hw_off} + {1'b0, hw_len};
   assign wr_bad   = (hw_off >= (IDX_W+1)'(WORDS)) || (hw_len == '0) ||
                     (wr_end > (IDX_W+2)'(WORDS));
   assign sig_or   = (cidx == SIG_IDX) ? SIG_HOLD : '0;

   assign s_we    = (st == S_HWR) && hw_beat;
   assign s_waddr = wbase + wcnt[IDX_W-1:0];
   assign s_raddr = (st == S_IDLE) ? hr_idx : cidx;
   assign s_clr   = (st == S_INV) && nv_ack && !nv_fail;

   nvm_shadow_store #(.WORDS(WORDS)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (s_we),
      .waddr (s_waddr),
      .wdata (hw_data),
      .clr   (s_clr),
      .raddr (s_raddr),
      .rmod  (s_mod),
      .rval  (s_val)
   );

   nvm_bank_pick #(.GOOD_CODE(SIG_CODE_VALID)) u_pick (
      .fld0  (sig0_fld),
      .fld1  (nv_rword[15:14]),
      .found (sel_found),
      .pick  (sel_bank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         act_bank    <= 1'b0;
         old_bank    <= 1'b0;
         cidx        <= '0;
         ridx        <= '0;
         wbase       <= '0;
         wcnt        <= '0;
         wlen        <= '0;
         cword       <= '0;
         sig0_fld    <= '0;
         hr_valid    <= 1'b0;
         hr_data     <= '0;
         hw_acc      <= 1'b0;
         hw_rej      <= 1'b0;
         commit_ok   <= 1'b0;
         commit_fail <= 1'b0;
      end else begin
         hr_valid    <= 1'b0;
         hw_acc      <= 1'b0;
         hw_rej      <= 1'b0;
         commit_ok   <= 1'b0;
         commit_fail <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (hr_req) begin
                  if (s_mod) begin
                     hr_data  <= s_val;
                     hr_valid <= 1'b1;
                  end else begin
                     ridx <= hr_idx;
                     st   <= S_HRD;
                  end
               end else if (hw_req) begin
                  if (wr_bad) begin
                     hw_rej <= 1'b1;
                  end else begin
                     hw_acc <= 1'b1;
                     wbase  <= hw_off[IDX_W-1:0];
                     wcnt   <= '0;
                     wlen   <= hw_len;
                     st     <= S_HWR;
                  end
               end else if (commit_req) begin
                  st <= S_DET0;
               end
            end
            S_HRD: if (nv_ack) begin
               hr_data  <= nv_rword;
               hr_valid <= 1'b1;
               st       <= S_IDLE;
            end
            S_HWR: if (hw_beat) begin
               wcnt <= wcnt + 1'b1;
               if ((wcnt + 1'b1) == wlen) st <= S_IDLE;
            end
            S_DET0: if (nv_ack) begin
               sig0_fld <= nv_rword[15:14];
               st       <= S_DET1;
            end
            S_DET1: if (nv_ack) begin
               if (sel_found) begin
                  old_bank <= sel_bank;
                  act_bank <= sel_bank;
                  st       <= S_ERASE;
               end else begin
                  commit_fail <= 1'b1;
                  st          <= S_IDLE;
               end
            end
            S_ERASE: if (nv_ack) begin
               if (nv_fail) begin
                  commit_fail <= 1'b1;
                  st          <= S_IDLE;
               end else begin
                  cidx <= '0;
                  st   <= S_PICK;
               end
            end
            S_PICK: begin
               if (s_mod) begin
                  cword <= s_val | sig_or;
                  st    <= S_CPLO;
               end else begin
                  st <= S_CPRD;
               end
            end
            S_CPRD: if (nv_ack) begin
               cword <= nv_rword | sig_or;
               st    <= S_CPLO;
            end
            S_CPLO: if (nv_ack) begin
               if (nv_fail) begin
                  commit_fail <= 1'b1;
                  st          <= S_IDLE;
               end else begin
                  st <= S_CPHI;
               end
            end
            S_CPHI: if (nv_ack) begin
               if (nv_fail) begin
                  commit_fail <= 1'b1;
                  st          <= S_IDLE;
               end else if (cidx == LAST_IDX) begin
                  st <= S_VRD;
               end else begin
                  cidx <= cidx + 1'b1;
                  st   <= S_PICK;
               end
            end
            S_VRD: if (nv_ack) begin
               cword <= nv_rword;
               st    <= S_VHI;
            end
            S_VHI: if (nv_ack) begin
               if (nv_fail) begin
                  commit_fail <= 1'b1;
                  st          <= S_IDLE;
               end else begin
                  st <= S_INV;
               end
            end
            S_INV: if (nv_ack) begin
               if (nv_fail) begin
                  commit_fail <= 1'b1;
               end else begin
                  act_bank  <= new_bank;
                  commit_ok <= 1'b1;
               end
               st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy   = (st != S_IDLE);
   assign nv_req = !(st inside {S_IDLE, S_HWR, S_PICK});

   always_comb begin
      nv_op    = NV_OP_PROG;
      nv_addr  = '0;
      nv_wbyte = '0;
      unique case (st)
         S_HRD:   begin nv_op = NV_OP_READ;  nv_addr = byte_at(act_bank, ridx, 1'b0);    end
         S_DET0:  begin nv_op = NV_OP_READ;  nv_addr = byte_at(1'b0, SIG_IDX, 1'b0);     end
         S_DET1:  begin nv_op = NV_OP_READ;  nv_addr = byte_at(1'b1, SIG_IDX, 1'b0);     end
         S_ERASE: begin nv_op = NV_OP_ERASE; nv_addr = byte_at(new_bank, '0, 1'b0);      end
         S_CPRD:  begin nv_op = NV_OP_READ;  nv_addr = byte_at(old_bank, cidx, 1'b0);    end
         S_CPLO:  begin nv_addr = byte_at(new_bank, cidx, 1'b0); nv_wbyte = cword[7:0];  end
         S_CPHI:  begin nv_addr = byte_at(new_bank, cidx, 1'b1); nv_wbyte = cword[15:8]; end
         S_VRD:   begin nv_op = NV_OP_READ;  nv_addr = byte_at(new_bank, SIG_IDX, 1'b0); end
         S_VHI:   begin nv_addr = byte_at(new_bank, SIG_IDX, 1'b1);
                        nv_wbyte = cword[15:8] & 8'hBF; end
         S_INV:   begin nv_addr = byte_at(old_bank, SIG_IDX, 1'b1); nv_wbyte = 8'h00;    end
         default: ;
      endcase
   end

   // R1: a shadow hit answers in the next cycle without a memory request
   a_r1_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && hr_req && s_mod) |=> (hr_valid && !nv_req));

   // R3: streaming write beats never reach the memory port
   a_r3_no_nv_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HWR) |-> !nv_req);

   // R5: one outcome per commit
   a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_ok && commit_fail));

   // R8: signature high byte carries 11b in its top bits during the copy
   a_r8_sig_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CPHI && cidx == SIG_IDX) |-> (nv_wbyte[7:6] == SIG_CODE_BUSY));

   // R12: a pending memory request keeps its operation and address
   a_r12_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && !nv_ack) |=> (nv_req && $stable(nv_addr) && $stable(nv_op)));

   // R12: outcome pulses coincide with a return to idle
   a_r12_idle_on_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ok || commit_fail) |-> !busy);

endmodule

// File: tb/nvm_shadow_commit_test.sv
module nvm_shadow_commit_test;

   localparam int W   = 32;
   localparam int BW  = 64;
   localparam int SIG = 19;
   localparam int IW  = 5;
   localparam int FAW = 8;
   localparam int NV  = 6;
   // {off[5:0], len[5:0], accept}
   localparam logic [12:0] VEC [NV] = '{
      {6'd3,  6'd2, 1'b1},
      {6'd31, 6'd1, 1'b1},
      {6'd32, 6'd1, 1'b0},
      {6'd0,  6'd0, 1'b0},
      {6'd30, 6'd3, 1'b0},
      {6'd19, 6'd1, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          hr_req = 0, hw_req = 0, hw_beat = 0, commit_req = 0;
   logic [IW-1:0] hr_idx = '0;
   logic [IW:0]   hw_off = '0, hw_len = '0;
   logic [15:0]   hw_data = '0;
   logic          hr_valid, hw_acc, hw_rej, busy, commit_ok, commit_fail;
   logic [15:0]   hr_data;
   logic          nv_req;
   logic [1:0]    nv_op;
   logic [FAW-1:0] nv_addr;
   logic [7:0]    nv_wbyte;
   logic          nv_ack = 0, nv_fail = 0;
   logic [15:0]   nv_rword = '0;

   nvm_shadow_commit uut (
      .clk(clk), .rst_n(rst_n),
      .hr_req(hr_req), .hr_idx(hr_idx), .hr_valid(hr_valid), .hr_data(hr_data),
      .hw_req(hw_req), .hw_off(hw_off), .hw_len(hw_len), .hw_beat(hw_beat),
      .hw_data(hw_data), .hw_acc(hw_acc), .hw_rej(hw_rej),
      .commit_req(commit_req), .busy(busy), .commit_ok(commit_ok),
      .commit_fail(commit_fail),
      .nv_req(nv_req), .nv_op(nv_op), .nv_addr(nv_addr), .nv_wbyte(nv_wbyte),
      .nv_ack(nv_ack), .nv_fail(nv_fail), .nv_rword(nv_rword)
   );

   // memory model: byte array, programming only clears bits
   logic [7:0] fm [0:4*BW-1];
   int lg_op [0:2047];
   int lg_addr [0:2047];
   int lg_byte [0:2047];
   int lg_n = 0;
   int pcnt = 0;
   int fail_at = -1;

   always @(posedge clk) begin
      nv_ack  <= 1'b0;
      nv_fail <= 1'b0;
      if (nv_req && !nv_ack) begin
         lg_op[lg_n]   = int'(nv_op);
         lg_addr[lg_n] = int'(nv_addr);
         lg_byte[lg_n] = int'(nv_wbyte);
         lg_n++;
         if (nv_op == 2'd0) begin
            nv_rword <= {fm[int'(nv_addr)+1], fm[int'(nv_addr)]};
         end else if (nv_op == 2'd1) begin
            if (pcnt == fail_at) nv_fail <= 1'b1;
            else fm[int'(nv_addr)] = fm[int'(nv_addr)] & nv_wbyte;
            pcnt++;
         end else begin
            for (int j = 0; j < 2*BW; j++) fm[int'(nv_addr)+j] = 8'hFF;
         end
         nv_ack <= 1'b1;
      end
   end

   int n_run = 0, n_fail = 0, cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // bench reference of the shadow
   logic        ex_mod [W];
   logic [15:0] ex_val [W];

   function automatic logic [15:0] fword(input int waddr);
      return {fm[2*waddr+1], fm[2*waddr]};
   endfunction

   task automatic host_read(input int idx, output logic [15:0] d, output int nops);
      int n0, t;
      @(negedge clk); hr_req = 1; hr_idx = IW'(idx); n0 = lg_n;
      @(negedge clk); hr_req = 0;
      t = 0;
      while (!hr_valid && t < 1000) begin @(negedge clk); t++; end
      d = hr_data;
      nops = lg_n - n0;
   endtask

   task automatic host_write(input int off, input int len, input logic [15:0] base,
                             output logic acc, output logic rej);
      @(negedge clk); hw_req = 1; hw_off = (IW+1)'(off); hw_len = (IW+1)'(len);
      @(negedge clk); hw_req = 0; acc = hw_acc; rej = hw_rej;
      if (acc) begin
         for (int k = 0; k < len; k++) begin
            hw_beat = 1; hw_data = base | 16'(k);
            ex_mod[off+k] = 1'b1; ex_val[off+k] = base | 16'(k);
            @(negedge clk);
         end
         hw_beat = 0;
      end
   endtask

   task automatic run_commit(input bit probe, output logic ok, output logic bad,
                             output logic seen_rd, output logic busy_mid);
      int t;
      seen_rd = 0; busy_mid = 0;
      @(negedge clk); commit_req = 1;
      @(negedge clk); commit_req = 0;
      t = 0;
      while (!(commit_ok || commit_fail) && t < 5000) begin
         if (probe && t == 5) begin busy_mid = busy; hr_req = 1; hr_idx = '0; end
         if (probe && t == 6) hr_req = 0;
         @(negedge clk);
         if (hr_valid) seen_rd = 1;
         t++;
      end
      ok = commit_ok; bad = commit_fail;
      chk("R12 busy low at outcome", 32'(busy), 32'd0);
   endtask

   int ex_op [0:2047];
   int ex_addr [0:2047];
   int ex_byte [0:2047];
   int ex_n;
   logic [15:0] ex_word [W];

   task automatic push(input int op, input int a, input int b);
      ex_op[ex_n] = op; ex_addr[ex_n] = a; ex_byte[ex_n] = b; ex_n++;
   endtask

   task automatic build_exp(input int obank);
      int ob, nb;
      logic [15:0] d;
      ob = obank ? BW : 0; nb = obank ? 0 : BW;
      ex_n = 0;
      push(0, 2*SIG, 0); push(0, 2*(BW+SIG), 0); push(2, 2*nb, 0);
      for (int i = 0; i < W; i++) begin
         if (!ex_mod[i]) push(0, 2*(ob+i), 0);
         d = ex_mod[i] ? ex_val[i] : fword(ob+i);
         if (i == SIG) d = d | 16'hC000;
         push(1, 2*(nb+i), int'(d[7:0]));
         push(1, 2*(nb+i)+1, int'(d[15:8]));
         ex_word[i] = (i == SIG) ? (d & 16'hBFFF) : d;
      end
      push(0, 2*(nb+SIG), 0);
      push(1, 2*(nb+SIG)+1, int'(ex_word[SIG][15:8]));
      push(1, 2*(ob+SIG)+1, 0);
   endtask

   initial begin
      logic [15:0] d;
      int nops, n0, mism, wi;
      logic acc, rej, ok, bad, seen, bm;

      for (int i = 0; i < 2*BW; i++) begin
         d = (i < BW) ? ((i == SIG) ? 16'h8013 : 16'h1000 + 16'(i)) : 16'hFFFF;
         fm[2*i] = d[7:0]; fm[2*i+1] = d[15:8];
      end
      for (int i = 0; i < W; i++) begin ex_mod[i] = 0; ex_val[i] = 16'hFFFF; end

      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 busy in reset", 32'(busy), 0);
      chk("R13 nv_req in reset", 32'(nv_req), 0);
      chk("R13 pulses in reset", {28'd0, hr_valid, hw_acc, commit_ok, commit_fail}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R13 idle after reset", {30'd0, busy, nv_req}, 0);

      // R2 read of an unchanged word from bank 0
      host_read(5, d, nops);
      chk("R2 unchanged read data", 32'(d), 32'h1005);
      chk("R2 read address", lg_addr[lg_n-1], 10);
      chk("R13 shadow starts unchanged", nops, 1);

      // vector table of host writes
      for (int v = 0; v < NV; v++) begin
         n0 = lg_n;
         host_write(int'(VEC[v][12:7]), int'(VEC[v][6:1]),
                    16'hA000 | 16'(int'(VEC[v][12:7]) << 4), acc, rej);
         chk(VEC[v][0] ? "R3 write accepted" : "R4 write rejected",
             {30'd0, acc, rej}, VEC[v][0] ? 32'd2 : 32'd1);
         chk("R3 no memory op during write", lg_n - n0, 0);
         wi = (int'(VEC[v][12:7]) < W) ? int'(VEC[v][12:7]) : W-1;
         host_read(wi, d, nops);
         chk(VEC[v][0] ? "R1 shadow read" : "R4 shadow unchanged", 32'(d),
             32'(ex_mod[wi] ? ex_val[wi] : fword(wi)));
         if (ex_mod[wi]) chk("R1 hit has no memory op", nops, 0);
      end

      // commit 1: bank 0 valid, copy into bank 1
      build_exp(0);
      n0 = lg_n;
      run_commit(1, ok, bad, seen, bm);
      chk("R10 commit ok", {30'd0, ok, bad}, 2);
      chk("R12 busy mid commit", 32'(bm), 1);
      chk("R12 read not taken while busy", 32'(seen), 0);
      chk("R7 operation count", lg_n - n0, ex_n);
      mism = 0;
      for (int i = 0; i < ex_n; i++)
         if (lg_op[n0+i] != ex_op[i] || lg_addr[n0+i] != ex_addr[i] ||
             (ex_op[i] == 1 && lg_byte[n0+i] != ex_byte[i])) mism++;
      chk("R6 R7 R9 R10 operation sequence", mism, 0);
      mism = 0;
      for (int i = 0; i < W; i++) if (fword(BW+i) != ex_word[i]) mism++;
      chk("R7 new bank contents", mism, 0);
      chk("R8 R9 new signature", 32'(fword(BW+SIG)), 32'hA130);
      chk("R10 old signature retired", 32'(fm[2*SIG+1]), 0);
      for (int i = 0; i < W; i++) begin ex_mod[i] = 0; ex_val[i] = 16'hFFFF; end

      host_read(3, d, nops);
      chk("R10 read from new bank", 32'(d), 32'hA030);
      chk("R10 shadow cleared", nops, 1);
      chk("R2 new bank address", lg_addr[lg_n-1], 2*(BW+3));
      host_read(20, d, nops);
      chk("R7 unchanged word copied", 32'(d), 32'h1014);

      // commit 2: bank 1 valid, fifth program fails
      host_write(7, 1, 16'h5A50, acc, rej);
      chk("R3 second write accepted", 32'(acc), 1);
      fail_at = pcnt + 4;
      n0 = lg_n;
      run_commit(0, ok, bad, seen, bm);
      fail_at = -1;
      chk("R11 commit fails", {30'd0, ok, bad}, 1);
      chk("R6 erase of bank 0 third", lg_op[n0+2], 2);
      chk("R5 bank 1 chosen", lg_addr[n0+2], 0);
      chk("R11 stops after failure", lg_op[lg_n-1] == 1 && lg_addr[lg_n-1] == 4, 1);
      chk("R11 old signature intact", 32'(fword(BW+SIG)), 32'hA130);
      chk("R11 new bank not validated", 32'(fm[2*SIG+1]), 32'hFF);
      host_read(7, d, nops);
      chk("R11 shadow kept", 32'(d), 32'h5A50);
      chk("R1 kept word is a hit", nops, 0);

      // commit 3: no valid bank
      fm[2*(BW+SIG)+1] = 8'h7F;
      n0 = lg_n;
      run_commit(0, ok, bad, seen, bm);
      chk("R5 no valid bank fails", {30'd0, ok, bad}, 1);
      chk("R5 only signature reads", lg_n - n0, 2);
      chk("R5 reads only", lg_op[n0] + lg_op[n0+1], 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule